// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters, each built from a low count byte and a high count byte. A counter advances either once per machine cycle, which is a fixed number of core clocks set by a parameter (twelve by default), or once for each falling transition seen on its own external event pin. A per-timer mode field chains the two bytes into a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads from the high byte. In split mode, timer 0 becomes two separate 8-bit counters and timer 1 stops.

Software reaches the block through a byte-wide register port with a write strobe, a 3-bit address and a combinational read path. The port reaches a mode byte, a control byte that holds run enables and overflow flags, and the four count bytes. The two overflow flags are also driven straight to output pins so that an interrupt controller can use them.

Top module: `dual_timer_unit`

## Requirements
- R1: In timer mode (C/T = 0), a running counter advances exactly once for every DIV core clocks, so a run window of DIV*N clocks adds N.
- R2: In counter mode (C/T = 1), the event pin is sampled once per machine cycle, and a high sample followed by a low sample adds one. A pulse whose low and high levels each last at least two machine cycles is counted exactly once.
- R3: Mode 0 (M1:M0 = 00) forms a 13-bit counter from low-byte bits 4:0 and the 8-bit high byte. Bits 7:5 of the low byte read as zero, and the step from high 0xFF / low 0x1F goes to zero and raises the timer's flag.
- R4: Mode 1 (M1:M0 = 01) forms a 16-bit counter with the high byte as the upper half. The step from 0xFFFF goes to zero and raises the flag.
- R5: Mode 2 (M1:M0 = 10) counts in the low byte only. A step from 0xFF loads the low byte from the high byte, leaves the high byte unchanged and raises the flag.
- R6: When timer 0 uses mode 3 (M1:M0 = 11), its low byte is an 8-bit counter that uses timer 0's run bit, gate and source, and it raises flag 0 on wrap. Its high byte counts machine cycles while run bit 1 is set and raises flag 1 on wrap. In this state, a wrap of timer 1 does not raise flag 1.
- R7: When timer 1 uses mode 3, timer 1 holds both of its count bytes, whatever the state of its run bit.
- R8: With a timer's gate bit set, the timer counts only while its run bit is set and its gate pin is high.
- R9: A write to either count byte of a timer takes effect in full, and that timer does not advance in the same cycle.
- R10: The control byte holds flag 1 at bit 7, run 1 at bit 6, flag 0 at bit 5 and run 0 at bit 4, and bits 3:0 read zero. A write stores all four of these bits. If the hardware raises a flag on the same edge as a write that clears it, the flag stays set. tf_out[1:0] shows {flag 1, flag 0}.
- R11: The register addresses are 0 for mode, 1 for control, 2 and 3 for timer 0 low and high, and 4 and 5 for timer 1 low and high. The mode byte holds timer 1 in bits 7:4 and timer 0 in bits 3:0, each nibble as {gate, C/T, M1, M0}. After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 3 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for sfr_addr (combinational) |
| ev_in | input | 2 | Event pins for timer 1 (bit 1) and timer 0 (bit 0) |
| gate_in | input | 2 | Gate pins for timer 1 (bit 1) and timer 0 (bit 0) |
| tf_out | output | 2 | Overflow flags {flag 1, flag 0} |

## Verification
The hardest case to reach is a count-byte write that falls on the same edge as a machine-cycle increment, because the machine-cycle phase cannot be seen at the ports. The stimulus leaves timer 0 running and rewrites its low byte on twelve consecutive clocks, reading it back after each write, so that one of those writes must meet an increment. Split mode needs a similar arrangement: timer 1 is set to wrap while timer 0's high byte is still far from wrapping, which separates the source of flag 1 from the run bit that both counters share.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    M_13BIT  = 2'd0,
    M_16BIT  = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    byte_t hi;
    byte_t lo;
    logic  wrap;
  } pair_t;

  localparam int          ADDR_W = 3;
  localparam int          N_TMR  = 2;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_T0L  = 3'd2;
  localparam logic [ADDR_W-1:0] A_T0H  = 3'd3;
  localparam logic [ADDR_W-1:0] A_T1L  = 3'd4;
  localparam logic [ADDR_W-1:0] A_T1H  = 3'd5;

  // One increment of a byte pair under the given mode (split: low byte only).
  function automatic pair_t pair_step(tmode_e m, byte_t hi, byte_t lo);
    pair_t       r;
    logic [13:0] v13;
    logic [16:0] v16;
    r   = '{hi: hi, lo: lo, wrap: 1'b0};
    v13 = '0;
    v16 = '0;
    unique case (m)
      M_13BIT: begin
        v13    = {1'b0, hi, lo[4:0]} + 14'd1;
        r.wrap = v13[13];
        r.hi   = v13[12:5];
        r.lo   = {3'b000, v13[4:0]};
      end
      M_16BIT: begin
        v16    = {1'b0, hi, lo} + 17'd1;
        r.wrap = v16[16];
        r.hi   = v16[15:8];
        r.lo   = v16[7:0];
      end
      M_RELOAD: begin
        if (lo == 8'hFF) begin
          r.lo   = hi;
          r.wrap = 1'b1;
        end else begin
          r.lo = lo + 8'd1;
        end
      end
      default: begin
        {r.wrap, r.lo} = {1'b0, lo} + 9'd1;
      end
    endcase
    return r;
  endfunction

  // Visible value of a low byte: the 13-bit mode hides bits 7:5.
  function automatic byte_t low_view(tmode_e m, byte_t lo);
    return (m == M_13BIT) ? {3'b000, lo[4:0]} : lo;
  endfunction

endpackage

// File: rtl/dtu_prescaler.sv
module dtu_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtu_fall_det.sv
module dtu_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic samp_q, prev_q;

  // Pin is looked at only on machine-cycle ticks; a 1 then 0 sample pair fires.
  assign fall = tick & prev_q & ~samp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      prev_q <= 1'b1;
    end else if (tick) begin
      samp_q <= pin;
      prev_q <= samp_q;
    end
  end
endmodule

// File: rtl/dtu_timer_core.sv
module dtu_timer_core
  import dtu_pkg::*;
#(
  parameter bit SPLIT_CAPABLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  input  logic   inc_lo,
  input  logic   inc_hi,
  input  logic   wr_lo,
  input  logic   wr_hi,
  input  byte_t  wdata,
  output byte_t  lo_q,
  output byte_t  hi_q,
  output logic   wrap_lo,
  output logic   wrap_hi
);
  logic  hold;
  logic  split;
  pair_t nxt;

  assign hold    = wr_lo | wr_hi;
  assign split   = (mode == M_SPLIT);
  assign nxt     = pair_step(mode, hi_q, lo_q);
  assign wrap_lo = inc_lo & ~hold & nxt.wrap;
  assign wrap_hi = SPLIT_CAPABLE & split & inc_hi & ~hold & (hi_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (hold) begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end else begin
      if (inc_lo) begin
        lo_q <= nxt.lo;
        if (!split) hi_q <= nxt.hi;
      end
      if (SPLIT_CAPABLE && split && inc_hi) hi_q <= hi_q + 8'd1;
    end
  end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic [N_TMR-1:0]  ev_in,
  input  logic [N_TMR-1:0]  gate_in,
  output logic [N_TMR-1:0]  tf_out
);
  byte_t            mode_r;
  logic [N_TMR-1:0] tr_q;
  logic [N_TMR-1:0] tf_q;

  logic             mc_tick;
  logic [N_TMR-1:0] fall_evt;

  dtu_prescaler #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(mc_tick));

  for (genvar g = 0; g < N_TMR; g++) begin : g_edge
    dtu_fall_det u_fd (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(ev_in[g]), .fall(fall_evt[g])
    );
  end

  // Mode nibble fields
  tmode_e m0, m1;
  logic   ct0, ct1, gt0, gt1;
  assign m0  = tmode_e'(mode_r[1:0]);
  assign ct0 = mode_r[2];
  assign gt0 = mode_r[3];
  assign m1  = tmode_e'(mode_r[5:4]);
  assign ct1 = mode_r[6];
  assign gt1 = mode_r[7];

  // Named count events
  logic run0, run1, t0_split, inc0_lo, inc0_hi, inc1;
  assign run0     = tr_q[0] & (~gt0 | gate_in[0]);
  assign run1     = tr_q[1] & (~gt1 | gate_in[1]);
  assign t0_split = (m0 == M_SPLIT);
  assign inc0_lo  = run0 & (ct0 ? fall_evt[0] : mc_tick);
  assign inc0_hi  = t0_split & tr_q[1] & mc_tick;
  assign inc1     = run1 & (ct1 ? fall_evt[1] : mc_tick) & (m1 != M_SPLIT);

  logic wr_mode, wr_ctrl, wr_t0l, wr_t0h, wr_t1l, wr_t1h;
  assign wr_mode = sfr_we & (sfr_addr == A_MODE);
  assign wr_ctrl = sfr_we & (sfr_addr == A_CTRL);
  assign wr_t0l  = sfr_we & (sfr_addr == A_T0L);
  assign wr_t0h  = sfr_we & (sfr_addr == A_T0H);
  assign wr_t1l  = sfr_we & (sfr_addr == A_T1L);
  assign wr_t1h  = sfr_we & (sfr_addr == A_T1H);

  byte_t t0_lo, t0_hi, t1_lo, t1_hi;
  logic  t0_wrap_lo, t0_wrap_hi, t1_wrap_lo, t1_wrap_hi;

  dtu_timer_core #(.SPLIT_CAPABLE(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .mode(m0),
    .inc_lo(inc0_lo), .inc_hi(inc0_hi),
    .wr_lo(wr_t0l), .wr_hi(wr_t0h), .wdata(sfr_wdata),
    .lo_q(t0_lo), .hi_q(t0_hi), .wrap_lo(t0_wrap_lo), .wrap_hi(t0_wrap_hi)
  );

  dtu_timer_core #(.SPLIT_CAPABLE(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .mode(m1),
    .inc_lo(inc1), .inc_hi(1'b0),
    .wr_lo(wr_t1l), .wr_hi(wr_t1h), .wdata(sfr_wdata),
    .lo_q(t1_lo), .hi_q(t1_hi), .wrap_lo(t1_wrap_lo), .wrap_hi(t1_wrap_hi)
  );

  // Flag raise events: in split mode timer 0's high half owns flag 1.
  logic [N_TMR-1:0] flag_set;
  assign flag_set[0] = t0_wrap_lo;
  assign flag_set[1] = t0_split ? t0_wrap_hi : (t1_wrap_lo | t1_wrap_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0;
      tr_q   <= '0;
      tf_q   <= '0;
    end else begin
      if (wr_mode) mode_r <= sfr_wdata;
      if (wr_ctrl) begin
        tr_q <= {sfr_wdata[6], sfr_wdata[4]};
        tf_q <= {sfr_wdata[7], sfr_wdata[5]} | flag_set;
      end else begin
        tf_q <= tf_q | flag_set;
      end
    end
  end

  assign tf_out = tf_q;

  always_comb begin
    unique case (sfr_addr)
      A_MODE:  sfr_rdata = mode_r;
      A_CTRL:  sfr_rdata = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], 4'b0000};
      A_T0L:   sfr_rdata = low_view(m0, t0_lo);
      A_T0H:   sfr_rdata = t0_hi;
      A_T1L:   sfr_rdata = low_view(m1, t1_lo);
      A_T1H:   sfr_rdata = t1_hi;
      default: sfr_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
  import dtu_pkg::*;
#(
  parameter int DIV = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic [N_TMR-1:0]  gate_in,
  input logic              mc_tick,
  input logic [N_TMR-1:0]  fall_evt,
  input logic              inc0_lo,
  input logic [7:0]        mode_r,
  input logic [N_TMR-1:0]  tf_q,
  input logic [7:0]        t0_lo,
  input logic [7:0]        t0_hi,
  input logic [7:0]        t1_lo,
  input logic [7:0]        t1_hi
);
  localparam int GW = (DIV > 1) ? $clog2(DIV) + 1 : 2;

  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (mc_tick) gap_q <= '0;
    else              gap_q <= gap_q + 1'b1;
  end

  logic w_t0, w_t1, w_ctl;
  assign w_t0  = sfr_we & ((sfr_addr == A_T0L) | (sfr_addr == A_T0H));
  assign w_t1  = sfr_we & ((sfr_addr == A_T1L) | (sfr_addr == A_T1H));
  assign w_ctl = sfr_we & (sfr_addr == A_CTRL);

  // R1: machine ticks are exactly DIV clocks apart
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mc_tick |-> (gap_q == GW'(DIV - 1)));

  // R2: events are only recognised on a machine tick
  assert_fall_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_evt) |-> mc_tick);

  // R5: reload from the high byte on low-byte wrap
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[1:0] == 2'b10 && inc0_lo && !w_t0 && t0_lo == 8'hFF) |=> (t0_lo == $past(t0_hi)));

  // R6 / R10: flag 0 rises only from a timer 0 increment or a software write
  assert_flag0_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tf_q[0]) && !$past(w_ctl)) |-> $past(inc0_lo));

  // R7: timer 1 in mode 3 holds its bytes
  assert_t1_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[5:4] == 2'b11 && !w_t1) |=> ($stable(t1_lo) && $stable(t1_hi)));

  // R8: gate low freezes timer 0's low byte
  assert_gate_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3] && !gate_in[0] && !w_t0) |=> $stable(t0_lo));

  // R9: written byte holds exactly the written value
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == A_T0L) |=> (t0_lo == $past(sfr_wdata)));
endmodule

bind dual_timer_unit dtu_checker #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .gate_in(gate_in), .mc_tick(mc_tick),
  .fall_evt(fall_evt), .inc0_lo(inc0_lo), .mode_r(mode_r), .tf_q(tf_q),
  .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi)
);

// File: tb/dual_timer_unit_tb.sv
module dual_timer_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_we = 1'b0;
  logic [2:0] sfr_addr = 3'd0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [1:0] ev_in = 2'b11;
  logic [1:0] gate_in = 2'b00;
  logic [1:0] tf_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_unit #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ev_in(ev_in),
    .gate_in(gate_in), .tf_out(tf_out)
  );

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // All tasks are entered just after a falling edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    sfr_addr = a;
    #1;
    v = int'(sfr_rdata);
  endtask

  task automatic stop_keep();
    wr(3'd1, {tf_out[1], 1'b0, tf_out[0], 1'b0, 4'b0000});
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ev_in = 2'b00;
      repeat (2*DIV) @(negedge clk);
      ev_in = 2'b11;
      repeat (2*DIV) @(negedge clk);
    end
  endtask

  // Bench view of one increment per mode (mode 3 not used here).
  function automatic void model_step(input int m, inout int hi, inout int lo, inout int wraps);
    int v;
    case (m)
      0: begin
        v = hi * 32 + (lo % 32) + 1;
        if (v == 8192) begin v = 0; wraps++; end
        hi = v / 32; lo = v % 32;
      end
      1: begin
        v = hi * 256 + lo + 1;
        if (v == 65536) begin v = 0; wraps++; end
        hi = v / 256; lo = v % 256;
      end
      default: begin
        if (lo == 255) begin lo = hi; wraps++; end
        else lo = lo + 1;
      end
    endcase
  endfunction

  task automatic run_case(input string req, input int x, input int m, input int ct,
                          input int hi0, input int lo0, input int n);
    int hi, lo, wraps, got;
    logic [3:0] nib;
    hi = hi0; lo = lo0; wraps = 0;
    for (int i = 0; i < n; i++) model_step(m, hi, lo, wraps);
    if (m == 0) lo = lo % 32;
    nib = {1'b0, ct[0], m[1:0]};
    wr(3'd1, 8'h00);
    wr(3'd0, (x == 1) ? {nib, 4'h0} : {4'h0, nib});
    wr((x == 1) ? 3'd4 : 3'd2, lo0[7:0]);
    wr((x == 1) ? 3'd5 : 3'd3, hi0[7:0]);
    wr(3'd1, (x == 1) ? 8'h40 : 8'h10);
    if (ct != 0) begin
      pulses(n);
      repeat (2*DIV) @(negedge clk);
    end else begin
      repeat (DIV*n - 1) @(negedge clk);
    end
    stop_keep();
    rd((x == 1) ? 3'd4 : 3'd2, got); check({req, " low byte"}, got, lo);
    rd((x == 1) ? 3'd5 : 3'd3, got); check({req, " high byte"}, got, hi);
    check({req, " flag"}, int'(tf_out[x]), (wraps > 0) ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int v;
    void'($urandom(32'd13579));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset values
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); check("R11 reset read", v, 0);
    end
    check("R11 reset flags", int'(tf_out), 0);

    // R3: hidden top bits of the low byte in mode 0
    wr(3'd2, 8'hFF);
    rd(3'd2, v); check("R3 low byte view", v, 8'h1F);

    // Directed mode cases
    run_case("R3 13-bit wrap", 0, 0, 0, 8'hFF, 8'h1F, 1);
    run_case("R3 13-bit carry", 1, 0, 1, 8'h07, 8'hFE, 3);
    run_case("R4 16-bit carry", 1, 1, 0, 8'h12, 8'hFF, 3);
    run_case("R4 16-bit wrap", 0, 1, 1, 8'hFF, 8'hFE, 3);
    run_case("R5 reload", 1, 2, 1, 8'hF0, 8'hFE, 3);
    run_case("R5 reload timer", 0, 2, 0, 8'h80, 8'hF0, 40);

    // R10: software set and clear of flags
    wr(3'd1, 8'hA0);
    check("R10 flags set by write", int'(tf_out), 3);
    rd(3'd1, v); check("R10 control readback", v, 8'hA0);
    wr(3'd1, 8'h00);
    check("R10 flags cleared by write", int'(tf_out), 0);

    // R6: split mode, both halves wrap
    wr(3'd0, 8'h13);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h50);
    repeat (2*DIV - 1) @(negedge clk);
    stop_keep();
    rd(3'd2, v); check("R6 split low", v, 8'h00);
    rd(3'd3, v); check("R6 split high", v, 8'h01);
    check("R6 split flags", int'(tf_out), 3);
    rd(3'd4, v); check("R6 timer1 low", v, 8'h01);
    // R6: timer 1 wrap does not raise flag 1 in split mode
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h40);
    repeat (2*DIV - 1) @(negedge clk);
    stop_keep();
    rd(3'd3, v); check("R6 split high under run 1", v, 8'h02);
    rd(3'd2, v); check("R6 split low idle", v, 8'h00);
    rd(3'd5, v); check("R6 timer1 wrapped high", v, 8'h00);
    check("R6 flag 1 not from timer 1", int'(tf_out), 0);

    // R7: timer 1 halted in mode 3
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h31);
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd1, 8'h40);
    repeat (5*DIV) @(negedge clk);
    stop_keep();
    rd(3'd4, v); check("R7 halted low", v, 8'h34);
    rd(3'd5, v); check("R7 halted high", v, 8'h12);
    check("R7 no flag", int'(tf_out), 0);

    // R8: gate
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h09);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate_in = 2'b00;
    wr(3'd1, 8'h10);
    repeat (4*DIV) @(negedge clk);
    rd(3'd2, v); check("R8 gate low holds", v, 0);
    gate_in = 2'b01;
    repeat (3*DIV) @(negedge clk);
    gate_in = 2'b00;
    repeat (DIV) @(negedge clk);
    stop_keep();
    rd(3'd2, v); check("R8 gate high counts", v, 3);

    // R9: write on every phase of the machine cycle
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    for (int k = 0; k < DIV; k++) begin
      wr(3'd2, 8'h80);
      rd(3'd2, v); check("R9 write beats increment", v, 8'h80);
    end
    rd(3'd3, v); check("R9 high untouched", v, 0);
    wr(3'd1, 8'h00);

    // Random cases: R1 (timer source) and R2 (event source)
    for (int i = 0; i < 24; i++) begin
      int x, m, ct, hi0, lo0, n;
      x   = int'($urandom % 2);
      m   = int'($urandom % 3);
      ct  = int'($urandom % 2);
      hi0 = ($urandom % 2 == 0) ? 255 : int'($urandom % 256);
      lo0 = ($urandom % 2 == 0) ? (224 + int'($urandom % 32)) : int'($urandom % 256);
      n   = (ct != 0) ? 1 + int'($urandom % 10) : 1 + int'($urandom % 40);
      run_case((ct != 0) ? "R2 random events" : "R1 random ticks", x, m, ct, hi0, lo0, n);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule